// File: doc/BRIEF.md
# Display Panel Command Word Serializer

This block turns short command requests into serial words for a display panel's control port. Each word carries a type bit and an 8-bit payload. Type 0 marks a register index and type 1 marks a parameter. The word goes out most significant bit first on three wires: an active-low select, a serial clock and a data line. A static input picks one of two framings. The first is a 16-bit word with a fixed marker pattern in its upper bits. The second is a bare 9-bit word made of the type bit followed by the payload.

A single request can hold a whole register write. The block then produces the index word and the parameter words that follow it, one after another. Between any two words, including the last word of one request and the first word of the next, it keeps the select line high for a minimum number of system clock cycles. The request side uses a valid/ready handshake and stalls while a request is in progress. An external error input is checked before each word is started. If it is high at that point, the rest of the request is dropped and a sticky error flag is raised. Software clears that flag with a clear input.

Top module: `panel_cmd_serializer`

## Requirements
- R1: After reset the select line is high, the serial clock is low, the data line is low, `req_ready` is high, and both `busy` and `err_flag` are low.
- R2: With `fmt_sel`=0 each word is 16 bits long. Bit 15 is 0, bits 14:12 are 1, bits 11:10 are 0, bit 9 is the type bit, bit 8 is 0 and bits 7:0 are the payload. For type t and payload d this is 0x7000 | (t<<9) | d.
- R3: With `fmt_sel`=1 each word is 9 bits long. The type bit is sent first, followed by the payload from bit 7 down to bit 0.
- R4: The select line is low for exactly the duration of one word. The serial clock rests low whenever the select line is high. Data changes only while the clock is low. Each high phase of the clock lasts `HALF_DIV` system cycles.
- R5: Operation code 0 (and code 3, which behaves the same way) sends one word built from `req_type` and `req_reg`.
- R6: Operation code 1 sends an index word (type 0, `req_reg`) and then one parameter word (type 1, `req_val[7:0]`).
- R7: Operation code 2 sends an index word (type 0, `req_reg`), then a parameter word with `req_val[15:8]`, then a parameter word with `req_val[7:0]`.
- R8: Between any two consecutive words the select line stays high for at least `GAP_CYCLES` system cycles. This applies across request boundaries as well.
- R9: `req_ready` is low and `busy` is high from the cycle after a request is accepted until its last word ends. A request offered during that time is ignored and never sent.
- R10: If `link_err` is high when the next word of a request would start, that word and every later word of the request are not sent, `err_flag` is set, and the block returns to idle.
- R11: `err_flag` stays set until `err_clr` is applied. If an abort and `err_clr` fall in the same cycle, the flag ends up set.
- R12: The framing is captured when a request is accepted. Changing `fmt_sel` while the request is running has no effect on its words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 1 | Framing select: 0 = 16-bit marked word, 1 = 9-bit word |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0/3 single word, 1 byte register write, 2 two-byte register write |
| req_type | input | 1 | Type bit for a single-word request |
| req_reg | input | 8 | Payload of a single word, or register index of a write |
| req_val | input | 16 | Value of a register write |
| link_err | input | 1 | External error condition, checked before each word starts |
| err_clr | input | 1 | Clears the sticky error flag |
| busy | output | 1 | A request is in progress |
| err_flag | output | 1 | Sticky error flag |
| panel_csn | output | 1 | Active-low select, low during a word |
| panel_sclk | output | 1 | Serial clock, rests low |
| panel_sdo | output | 1 | Serial data, most significant bit first |

## Verification
The abort of a request and a software clear of the error flag can land in the same cycle. The bench provokes this by holding `link_err` high, offering a request, and raising `err_clr` in exactly the cycle in which the pending word is checked and dropped. It then judges that `err_flag` is still set, that no select pulse appeared and that the block is idle again. A second overlap is a request offered while another is still running. The bench judges this by counting the words captured on the serial side.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int FRAME_W = 16;
  localparam int LEN_W   = 5;

  typedef enum logic [1:0] {
    OP_SINGLE = 2'd0,
    OP_BYTE   = 2'd1,
    OP_HALF   = 2'd2,
    OP_ALT    = 2'd3
  } op_e;

  typedef struct packed {
    logic [FRAME_W-1:0] pat;
    logic [LEN_W-1:0]   len;
  } frame_t;

  // Word is left-justified so that the shifter always starts at bit 15.
  function automatic frame_t build_frame(input logic nine, input logic kind,
                                         input logic [7:0] pay);
    frame_t f;
    if (nine) begin
      f.pat = {kind, pay, 7'b0};
      f.len = LEN_W'(9);
    end else begin
      f.pat = 16'h7000 | {6'b0, kind, 9'b0} | {8'b0, pay};
      f.len = LEN_W'(16);
    end
    return f;
  endfunction

endpackage

// File: rtl/pcs_shifter.sv
module pcs_shifter
  import pcs_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  frame_t frame,
  output logic   done,
  output logic   csn,
  output logic   sclk,
  output logic   sdo
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0]      div_q;
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;
  logic               act_q;
  logic               sclk_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sh_q   <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q  <= 1'b1;
          sh_q   <= frame.pat;
          left_q <= frame.len;
          div_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DW'(HALF_DIV - 1)) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        if (sclk_q) begin
          sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
          left_q <= left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign done = done_q;
  assign csn  = ~act_q;
  assign sclk = sclk_q;
  assign sdo  = sh_q[FRAME_W-1];

endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
  import pcs_pkg::*;
#(
  parameter int GAP_CYCLES = 20000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        req_type,
  input  logic [7:0]  req_reg,
  input  logic [15:0] req_val,
  input  logic        fmt_sel,
  input  logic        link_err,
  input  logic        tx_done,
  output logic        req_ready,
  output logic        busy,
  output logic        tx_start,
  output frame_t      tx_frame,
  output logic        abort
);

  localparam int GW = $clog2(GAP_CYCLES + 2);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_SEND} st_e;

  st_e         st_q;
  op_e         op_q;
  logic        kind_q;
  logic        nine_q;
  logic [7:0]  reg_q;
  logic [15:0] val_q;
  logic [1:0]  idx_q;
  logic [1:0]  last_idx;
  logic [GW-1:0] gap_q;
  logic        w_kind;
  logic [7:0]  w_pay;

  always_comb begin
    case (op_q)
      OP_BYTE: last_idx = 2'd1;
      OP_HALF: last_idx = 2'd2;
      default: last_idx = 2'd0;
    endcase
  end

  always_comb begin
    w_kind = 1'b1;
    w_pay  = val_q[7:0];
    if (idx_q == 2'd0) begin
      w_kind = (op_q == OP_SINGLE || op_q == OP_ALT) ? kind_q : 1'b0;
      w_pay  = reg_q;
    end else if (idx_q == 2'd1 && op_q == OP_HALF) begin
      w_pay = val_q[15:8];
    end
  end

  assign tx_frame  = build_frame(nine_q, w_kind, w_pay);
  assign tx_start  = (st_q == S_PEND) && (gap_q == '0) && !link_err;
  assign abort     = (st_q == S_PEND) && link_err;
  assign req_ready = (st_q == S_IDLE);
  assign busy      = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      op_q   <= OP_SINGLE;
      kind_q <= 1'b0;
      nine_q <= 1'b0;
      reg_q  <= '0;
      val_q  <= '0;
      idx_q  <= '0;
      gap_q  <= '0;
    end else begin
      if (tx_done)
        gap_q <= GW'(GAP_CYCLES);
      else if (gap_q != '0)
        gap_q <= gap_q - GW'(1);

      case (st_q)
        S_IDLE: if (req_valid) begin
          op_q   <= op_e'(req_op);
          kind_q <= req_type;
          nine_q <= fmt_sel;
          reg_q  <= req_reg;
          val_q  <= req_val;
          idx_q  <= '0;
          st_q   <= S_PEND;
        end
        S_PEND: begin
          if (link_err)      st_q <= S_IDLE;
          else if (tx_start) st_q <= S_SEND;
        end
        S_SEND: if (tx_done) begin
          if (idx_q == last_idx) begin
            st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
            st_q  <= S_PEND;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/panel_cmd_serializer.sv
module panel_cmd_serializer
  import pcs_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int GAP_CYCLES = 20000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fmt_sel,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic        req_type,
  input  logic [7:0]  req_reg,
  input  logic [15:0] req_val,
  input  logic        link_err,
  input  logic        err_clr,
  output logic        busy,
  output logic        err_flag,
  output logic        panel_csn,
  output logic        panel_sclk,
  output logic        panel_sdo
);

  logic   start_w;
  logic   done_w;
  logic   abort_w;
  frame_t frame_w;
  logic   err_q;

  pcs_sequencer #(.GAP_CYCLES(GAP_CYCLES)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_type  (req_type),
    .req_reg   (req_reg),
    .req_val   (req_val),
    .fmt_sel   (fmt_sel),
    .link_err  (link_err),
    .tx_done   (done_w),
    .req_ready (req_ready),
    .busy      (busy),
    .tx_start  (start_w),
    .tx_frame  (frame_w),
    .abort     (abort_w)
  );

  pcs_shifter #(.HALF_DIV(HALF_DIV)) shf_i (
    .clk   (clk),
    .rst   (rst),
    .start (start_w),
    .frame (frame_w),
    .done  (done_w),
    .csn   (panel_csn),
    .sclk  (panel_sclk),
    .sdo   (panel_sdo)
  );

  // Setting wins over clearing in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (abort_w) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int GAP_CYCLES = 20000
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic link_err,
  input logic err_clr,
  input logic err_flag,
  input logic abort,
  input logic panel_csn,
  input logic panel_sclk,
  input logic panel_sdo
);

  logic [31:0] hi_cnt;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      seen_q <= 1'b0;
    end else begin
      if (panel_csn) begin
        if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 32'd1;
      end else begin
        hi_cnt <= '0;
        seen_q <= 1'b1;
      end
    end
  end

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    panel_csn |-> !panel_sclk); // R4
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!panel_csn && panel_sclk) |-> $stable(panel_sdo)); // R4
  AST_WORD_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(panel_csn) && seen_q) |-> (hi_cnt >= 32'(GAP_CYCLES))); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy); // R9
  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    $fell(panel_csn) |-> !$past(link_err)); // R10
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    abort |=> err_flag); // R11
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag); // R11

endmodule

bind panel_cmd_serializer pcs_checker #(.GAP_CYCLES(GAP_CYCLES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .link_err   (link_err),
  .err_clr    (err_clr),
  .err_flag   (err_flag),
  .abort      (abort_w),
  .panel_csn  (panel_csn),
  .panel_sclk (panel_sclk),
  .panel_sdo  (panel_sdo)
);

// File: tb/panel_cmd_serializer_tb_top.sv
`timescale 1ns/1ps
module panel_cmd_serializer_tb_top;

  localparam int HALF = 2;
  localparam int GAP  = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_sel = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic        req_type = 1'b0;
  logic [7:0]  req_reg = 8'd0;
  logic [15:0] req_val = 16'd0;
  logic        link_err = 1'b0;
  logic        err_clr = 1'b0;
  logic        busy, err_flag, panel_csn, panel_sclk, panel_sdo;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  panel_cmd_serializer #(.HALF_DIV(HALF), .GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_type(req_type),
    .req_reg(req_reg), .req_val(req_val), .link_err(link_err),
    .err_clr(err_clr), .busy(busy), .err_flag(err_flag),
    .panel_csn(panel_csn), .panel_sclk(panel_sclk), .panel_sdo(panel_sdo)
  );

  // Serial-side capture
  logic [15:0] cur = '0;
  int          nb = 0;
  logic [15:0] cap_w [0:15];
  int          cap_n [0:15];
  int          ncap = 0;

  always @(posedge panel_sclk) if (!panel_csn) begin
    cur = {cur[14:0], panel_sdo};
    nb++;
  end

  always @(posedge panel_csn) begin
    if (ncap < 16) begin
      cap_w[ncap] = cur;
      cap_n[ncap] = nb;
    end
    ncap++;
    cur = '0;
    nb = 0;
  end

  // Timing monitor
  logic prev_csn = 1'b1;
  logic seen = 1'b0;
  int   hi_run = 0;
  int   min_gap = 1000000;
  int   sclk_run = 0;
  int   bad_half = 0;
  int   bad_idle = 0;

  always @(negedge clk) if (!rst) begin
    if (panel_csn && panel_sclk) bad_idle++;
    if (prev_csn && !panel_csn && seen && hi_run < min_gap) min_gap = hi_run;
    if (panel_csn) hi_run++;
    else begin
      hi_run = 0;
      seen = 1'b1;
    end
    if (panel_sclk) sclk_run++;
    else begin
      if (sclk_run != 0 && sclk_run != HALF) bad_half++;
      sclk_run = 0;
    end
    prev_csn = panel_csn;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f16(input logic t, input logic [7:0] d);
    return 16'h7000 | (16'(t) << 9) | 16'(d);
  endfunction

  function automatic logic [15:0] f9(input logic t, input logic [7:0] d);
    return {7'b0, t, d};
  endfunction

  task automatic clear_caps();
    ncap = 0;
  endtask

  task automatic send(input logic [1:0] op, input logic t, input logic [7:0] r,
                      input logic [15:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_type = t; req_reg = r; req_val = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 csn", 32'(panel_csn), 32'd1);
    chk("R1 sclk", 32'(panel_sclk), 32'd0);
    chk("R1 sdo", 32'(panel_sdo), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 err", 32'(err_flag), 32'd0);
  endtask

  task automatic t_single16();
    clear_caps(); fmt_sel = 1'b0;
    send(2'd0, 1'b1, 8'hA5, 16'h0);
    wait_idle();
    chk("R5 count", 32'(ncap), 32'd1);
    chk("R2 word", 32'(cap_w[0]), 32'(f16(1'b1, 8'hA5)));
    chk("R2 len", 32'(cap_n[0]), 32'd16);
    clear_caps();
    send(2'd3, 1'b0, 8'h5A, 16'h0);
    wait_idle();
    chk("R5 alt code", 32'(cap_w[0]), 32'(f16(1'b0, 8'h5A)));
  endtask

  task automatic t_single9();
    clear_caps(); fmt_sel = 1'b1;
    send(2'd0, 1'b0, 8'h3C, 16'h0);
    send(2'd0, 1'b1, 8'hFF, 16'h0);
    wait_idle();
    chk("R3 count", 32'(ncap), 32'd2);
    chk("R3 word0", 32'(cap_w[0]), 32'(f9(1'b0, 8'h3C)));
    chk("R3 len0", 32'(cap_n[0]), 32'd9);
    chk("R3 word1", 32'(cap_w[1]), 32'(f9(1'b1, 8'hFF)));
  endtask

  task automatic t_byte();
    clear_caps(); fmt_sel = 1'b0;
    send(2'd1, 1'b1, 8'h39, 16'h0024);
    wait_idle();
    chk("R6 count", 32'(ncap), 32'd2);
    chk("R6 index", 32'(cap_w[0]), 32'(f16(1'b0, 8'h39)));
    chk("R6 value", 32'(cap_w[1]), 32'(f16(1'b1, 8'h24)));
  endtask

  task automatic t_word();
    clear_caps(); fmt_sel = 1'b1;
    send(2'd2, 1'b1, 8'hEF, 16'hD0E8);
    wait_idle();
    chk("R7 count", 32'(ncap), 32'd3);
    chk("R7 index", 32'(cap_w[0]), 32'(f9(1'b0, 8'hEF)));
    chk("R7 high", 32'(cap_w[1]), 32'(f9(1'b1, 8'hD0)));
    chk("R7 low", 32'(cap_w[2]), 32'(f9(1'b1, 8'hE8)));
  endtask

  task automatic t_busy_ignore();
    clear_caps(); fmt_sel = 1'b0;
    send(2'd2, 1'b0, 8'h12, 16'h3456);
    chk("R9 ready low", 32'(req_ready), 32'd0);
    chk("R9 busy high", 32'(busy), 32'd1);
    req_op = 2'd0; req_type = 1'b1; req_reg = 8'h55; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk("R9 words", 32'(ncap), 32'd3);
    chk("R9 last", 32'(cap_w[2]), 32'(f16(1'b1, 8'h56)));
  endtask

  task automatic t_fmt_hold();
    clear_caps(); fmt_sel = 1'b0;
    send(2'd1, 1'b0, 8'h1D, 16'h00A0);
    fmt_sel = 1'b1;
    wait_idle();
    chk("R12 len0", 32'(cap_n[0]), 32'd16);
    chk("R12 len1", 32'(cap_n[1]), 32'd16);
    chk("R12 value", 32'(cap_w[1]), 32'(f16(1'b1, 8'hA0)));
    fmt_sel = 1'b0;
  endtask

  task automatic t_err_abort();
    clear_caps(); fmt_sel = 1'b0;
    send(2'd2, 1'b0, 8'hEF, 16'hD0E8);
    while (panel_csn) @(negedge clk);
    link_err = 1'b1;
    wait_idle();
    chk("R10 words", 32'(ncap), 32'd1);
    chk("R10 first", 32'(cap_w[0]), 32'(f16(1'b0, 8'hEF)));
    chk("R10 err", 32'(err_flag), 32'd1);
    link_err = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 sticky", 32'(err_flag), 32'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R11 cleared", 32'(err_flag), 32'd0);
  endtask

  task automatic t_collide();
    clear_caps();
    link_err = 1'b1;
    @(negedge clk);
    req_op = 2'd0; req_type = 1'b0; req_reg = 8'h11; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R11 set wins", 32'(err_flag), 32'd1);
    chk("R10 idle", 32'(busy), 32'd0);
    link_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 no word", 32'(ncap), 32'd0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single16();
    t_single9();
    t_byte();
    t_word();
    t_busy_ignore();
    t_fmt_hold();
    t_err_abort();
    t_collide();
    t_single16();
    chk("R4 high phase", 32'(bad_half), 32'd0);
    chk("R4 idle clock", 32'(bad_idle), 32'd0);
    chk("R8 min gap", 32'(min_gap >= GAP), 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule